// File: doc/BRIEF.md
# Masked Time-of-Day Alarm

This block is the alarm unit of a bytewide real-time clock. Software programs three alarm bytes on the clock's register bus: minutes, hours and day of week. Each byte holds a BCD value in the same layout as the matching time byte, with a "don't care" mask in its top bit. The clock core supplies the current BCD minutes, hours and day, a level that is high while hundredths of a second read 99, and a one-cycle strobe when seconds roll from 59 to 00.

The block compares the time against the alarm bytes during the hundredths-equals-99 interval. It commits the result at the seconds rollover, so a matching minute raises a sticky alarm flag exactly once. Masking fields from the day downward gives the alarm modes:

| Masked fields | Alarm fires |
|---|---|
| none | once a week |
| day | once a day |
| day and hours | once an hour |
| day, hours and minutes | every minute |

An interrupt-enable level taken from the command register gates the flag onto an active-low interrupt output. Any read or write of an alarm byte clears the flag, which acknowledges the interrupt.

Top module: `tod_alarm`

## Requirements
- R1: After reset the alarm flag is 0, the interrupt output is 1, and reads of all three alarm bytes return 0x00.
- R2: A write to address 3 (minutes) or address 5 (hours) stores all eight data bits, and a read of that address returns the stored byte.
- R3: A write to address 7 (day) keeps bit 7 and bits 2..0; bits 6..3 of the day byte always read 0 (writing 0xFF reads back 0x87).
- R4: With every mask bit (bit 7) clear, the flag is set only when the minutes value (bits 6..0), the hours value (bits 6..0) and the day value (bits 2..0) all equal the current time; a mismatch in any one field sets nothing.
- R5: A mask bit at 1 removes its field from the comparison. Masking the day gives a daily alarm, masking day and hours gives an hourly alarm, and masking all three gives an alarm at every minute rollover.
- R6: The comparison is sampled on every clock with the hundredths-equals-99 input high, and the last such sample is kept. The flag is set only by a seconds-rollover strobe, and becomes visible one clock after the edge that samples the strobe.
- R7: Each sampled match is consumed by the rollover that commits it; a further rollover strobe with no new sampling interval in between does not set the flag.
- R8: The flag is sticky. It is cleared only by reset or by an alarm-byte access, and accesses to any other address leave it unchanged.
- R9: A read or write of address 3, 5 or 7 clears the flag one clock later. If that access falls in the same cycle as a committing rollover, the flag is set.
- R10: The interrupt output is 0 exactly while the flag is 1 and the enable input is 1, and changing the enable input never changes the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (5) | Register bus address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | DATA_W (8) | Write data |
| busRdData | output | DATA_W (8) | Read data of the alarm bytes; 0 when no alarm byte is read |
| curMin | input | DATA_W (8) | Current BCD minutes from the clock core |
| curHour | input | DATA_W (8) | Current BCD hours, including the 12/24-hour and PM bits |
| curDay | input | DATA_W (8) | Current day of week |
| hund99 | input | 1 | High while hundredths read 99 (the sampling interval) |
| secRoll | input | 1 | One-cycle strobe when seconds roll from 59 to 00 |
| irqEnable | input | 1 | Alarm interrupt enable from the command register |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIrqN | output | 1 | Active-low alarm interrupt |

## Verification
The alarm state is a stored byte, a pending sample and the flag, so a fault shows at the ports in one of two ways. It may show as a wrong byte on the very read that follows a write. It may also show as a flag that differs from the expected one, one clock after the rollover strobe or one clock after an access. The directed tests cover the following:
- Every mask combination, with a mismatch in each single field.
- A sampling interval whose last cycle disagrees with its first.
- A rollover that has no new sampling interval before it.
- An access in the same cycle as a rollover.

A lost or repeated commit, or a clear from the wrong address, therefore shows within a few cycles as a flag or interrupt mismatch.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

  localparam int NUM_FIELDS = 3;

  // Field order inside the alarm unit
  localparam int FIELD_MIN  = 0;
  localparam int FIELD_HOUR = 1;
  localparam int FIELD_DAY  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_FIELDS-1:0] wrSel;  // write this alarm byte
    logic [NUM_FIELDS-1:0] rdSel;  // drive this alarm byte on read data
  } ctrlStrobes_t;

endpackage

// File: rtl/tod_alarm_dp.sv
module tod_alarm_dp
  import tod_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DAY_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDay,
  output logic [DATA_W-1:0] busRdData,
  output logic              matchNow
);

  localparam logic [DATA_W-1:0] MASK_BIT = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] WIDE_VAL = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] DAY_VAL  = {{(DATA_W-DAY_W){1'b0}}, {DAY_W{1'b1}}};

  // Value bits that take part in the comparison for one field
  function automatic logic [DATA_W-1:0] valueMask(input int idx);
    return (idx == FIELD_DAY) ? DAY_VAL : WIDE_VAL;
  endfunction

  logic [DATA_W-1:0]     fieldReg [NUM_FIELDS];
  logic [DATA_W-1:0]     curVec   [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fieldHit;

  assign curVec[FIELD_MIN]  = curMin;
  assign curVec[FIELD_HOUR] = curHour;
  assign curVec[FIELD_DAY]  = curDay;

  // Alarm byte storage; unused bits are never stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FIELDS; i++) fieldReg[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (strobes.wrSel[i]) fieldReg[i] <= busWrData & (valueMask(i) | MASK_BIT);
      end
    end
  end

  // Per-field compare, bypassed by the field's mask bit
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    logic [DATA_W-1:0] diff;
    assign diff        = (curVec[g] ^ fieldReg[g]) & valueMask(g);
    assign fieldHit[g] = fieldReg[g][DATA_W-1] | (diff == '0);
  end

  assign matchNow = &fieldHit;

  // Read mux
  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (strobes.rdSel[i]) busRdData = busRdData | fieldReg[i];
    end
  end

endmodule

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MIN_ADDR  = 3,
  parameter int HOUR_ADDR = 5,
  parameter int DAY_ADDR  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              hund99,
  input  logic              secRoll,
  input  logic              matchNow,
  input  logic              irqEnable,
  output ctrlStrobes_t      strobes,
  output logic              alarmFlag,
  output logic              alarmIrqN
);

  localparam logic [ADDR_W-1:0] FIELD_ADDR [NUM_FIELDS] = '{
    ADDR_W'(MIN_ADDR), ADDR_W'(HOUR_ADDR), ADDR_W'(DAY_ADDR)
  };

  logic [NUM_FIELDS-1:0] addrHit;
  logic                  alarmAccess;
  logic                  pendingHit;
  logic                  commitHit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
    assign addrHit[g]       = (busAddr == FIELD_ADDR[g]);
    assign strobes.wrSel[g] = busWrEn & addrHit[g];
    assign strobes.rdSel[g] = busRdEn & addrHit[g];
  end

  assign alarmAccess = (busWrEn | busRdEn) & (|addrHit);
  assign commitHit   = secRoll & pendingHit;

  // Latest sample taken in the hundredths-99 interval; consumed by a rollover
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pendingHit <= 1'b0;
    else if (hund99)  pendingHit <= matchNow;
    else if (secRoll) pendingHit <= 1'b0;
  end

  // Sticky flag: a commit wins over a same-cycle clearing access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            alarmFlag <= 1'b0;
    else if (commitHit)   alarmFlag <= 1'b1;
    else if (alarmAccess) alarmFlag <= 1'b0;
  end

  assign alarmIrqN = ~(alarmFlag & irqEnable);

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int DAY_W     = 3,
  parameter int MIN_ADDR  = 3,
  parameter int HOUR_ADDR = 5,
  parameter int DAY_ADDR  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDay,
  input  logic              hund99,
  input  logic              secRoll,
  input  logic              irqEnable,
  output logic              alarmFlag,
  output logic              alarmIrqN
);

  ctrlStrobes_t strobes;
  logic         matchNow;

  tod_alarm_ctrl #(
    .ADDR_W(ADDR_W), .MIN_ADDR(MIN_ADDR), .HOUR_ADDR(HOUR_ADDR), .DAY_ADDR(DAY_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .hund99(hund99), .secRoll(secRoll), .matchNow(matchNow), .irqEnable(irqEnable),
    .strobes(strobes), .alarmFlag(alarmFlag), .alarmIrqN(alarmIrqN)
  );

  tod_alarm_dp #(.DATA_W(DATA_W), .DAY_W(DAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .busRdData(busRdData), .matchNow(matchNow)
  );

endmodule

// File: rtl/tod_alarm_checker.sv
module tod_alarm_checker #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int DAY_W     = 3,
  parameter int MIN_ADDR  = 3,
  parameter int HOUR_ADDR = 5,
  parameter int DAY_ADDR  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              secRoll,
  input logic              irqEnable,
  input logic              alarmFlag,
  input logic              alarmIrqN
);

  logic isAlarmAddr;
  logic alarmAccess;
  assign isAlarmAddr = (busAddr == ADDR_W'(MIN_ADDR)) || (busAddr == ADDR_W'(HOUR_ADDR)) ||
                       (busAddr == ADDR_W'(DAY_ADDR));
  assign alarmAccess = (busWrEn || busRdEn) && isAlarmAddr;

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> (!alarmFlag && alarmIrqN));

  a_r3_day_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(DAY_ADDR)) |-> (busRdData[DATA_W-2:DAY_W] == '0));

  a_r6_set_by_roll: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(secRoll));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !alarmAccess) |=> alarmFlag);

  a_r9_access_clears: assert property (@(posedge clk) disable iff (!rstN)
    (alarmAccess && !secRoll) |=> !alarmFlag);

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag || !irqEnable) |-> alarmIrqN);

endmodule

bind tod_alarm tod_alarm_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W),
  .MIN_ADDR(MIN_ADDR), .HOUR_ADDR(HOUR_ADDR), .DAY_ADDR(DAY_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busRdData(busRdData), .secRoll(secRoll), .irqEnable(irqEnable),
  .alarmFlag(alarmFlag), .alarmIrqN(alarmIrqN)
);

// File: tb/tb_tod_alarm.sv
module tb_tod_alarm;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] curMin = '0;
  logic [7:0] curHour = '0;
  logic [7:0] curDay = '0;
  logic       hund99 = 1'b0;
  logic       secRoll = 1'b0;
  logic       irqEnable = 1'b0;
  logic       alarmFlag;
  logic       alarmIrqN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .curMin(curMin), .curHour(curHour),
    .curDay(curDay), .hund99(hund99), .secRoll(secRoll), .irqEnable(irqEnable),
    .alarmFlag(alarmFlag), .alarmIrqN(alarmIrqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic clearFlag();
    logic [7:0] d;
    busRead(5'd3, d);
  endtask

  // One sampling interval followed by a rollover strobe
  task automatic minuteTick(input logic [7:0] m, input logic [7:0] h, input logic [7:0] dy);
    @(negedge clk);
    curMin = m; curHour = h; curDay = dy; hund99 = 1'b1;
    @(negedge clk);
    hund99 = 1'b0; secRoll = 1'b1;
    @(negedge clk);
    secRoll = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 flag", {7'd0, alarmFlag}, 8'h00);
    check("R1 irq", {7'd0, alarmIrqN}, 8'h01);
    busRead(5'd3, d); check("R1 min reg", d, 8'h00);
    busRead(5'd5, d); check("R1 hour reg", d, 8'h00);
    busRead(5'd7, d); check("R1 day reg", d, 8'h00);
  endtask

  task automatic testRegisters();
    logic [7:0] d;
    busWrite(5'd3, 8'h45); busRead(5'd3, d); check("R2 min readback", d, 8'h45);
    busWrite(5'd5, 8'h92); busRead(5'd5, d); check("R2 hour readback", d, 8'h92);
    busWrite(5'd7, 8'hFF); busRead(5'd7, d); check("R3 day upper bits", d, 8'h87);
    busRead(5'd4, d); check("R2 other addr reads 0", d, 8'h00);
  endtask

  task automatic testExact();
    busWrite(5'd3, 8'h30); busWrite(5'd5, 8'h08); busWrite(5'd7, 8'h03);
    minuteTick(8'h30, 8'h08, 8'h03);
    check("R4 exact match sets", {7'd0, alarmFlag}, 8'h01);
    clearFlag();
    check("R9 read clears", {7'd0, alarmFlag}, 8'h00);
    minuteTick(8'h30, 8'h08, 8'h04);
    check("R4 day mismatch", {7'd0, alarmFlag}, 8'h00);
    minuteTick(8'h31, 8'h08, 8'h03);
    check("R4 min mismatch", {7'd0, alarmFlag}, 8'h00);
    minuteTick(8'h30, 8'h09, 8'h03);
    check("R4 hour mismatch", {7'd0, alarmFlag}, 8'h00);
  endtask

  task automatic testMasks();
    busWrite(5'd7, 8'h83);
    minuteTick(8'h30, 8'h08, 8'h05);
    check("R5 daily fires", {7'd0, alarmFlag}, 8'h01);
    clearFlag();
    minuteTick(8'h31, 8'h08, 8'h05);
    check("R5 daily still checks min", {7'd0, alarmFlag}, 8'h00);
    busWrite(5'd5, 8'h88);
    minuteTick(8'h30, 8'h11, 8'h02);
    check("R5 hourly fires", {7'd0, alarmFlag}, 8'h01);
    clearFlag();
    minuteTick(8'h29, 8'h11, 8'h02);
    check("R5 hourly still checks min", {7'd0, alarmFlag}, 8'h00);
    busWrite(5'd3, 8'hB0);
    minuteTick(8'h17, 8'h22, 8'h06);
    check("R5 per-minute fires", {7'd0, alarmFlag}, 8'h01);
    clearFlag();
  endtask

  task automatic testSampling();
    // alarm 12:45 day 1, no masks
    busWrite(5'd3, 8'h45); busWrite(5'd5, 8'h12); busWrite(5'd7, 8'h01);
    @(negedge clk); curMin = 8'h45; curHour = 8'h12; curDay = 8'h01; hund99 = 1'b1;
    @(negedge clk); hund99 = 1'b0;
    @(negedge clk);
    check("R6 no set before roll", {7'd0, alarmFlag}, 8'h00);
    secRoll = 1'b1;
    @(negedge clk); secRoll = 1'b0;
    check("R6 set after roll", {7'd0, alarmFlag}, 8'h01);
    clearFlag();
    @(negedge clk); secRoll = 1'b1;
    @(negedge clk); secRoll = 1'b0;
    check("R7 second roll ignored", {7'd0, alarmFlag}, 8'h00);
    @(negedge clk); curMin = 8'h45; hund99 = 1'b1;
    @(negedge clk); curMin = 8'h46;
    @(negedge clk); hund99 = 1'b0; secRoll = 1'b1;
    @(negedge clk); secRoll = 1'b0;
    check("R6 last sample kept", {7'd0, alarmFlag}, 8'h00);
  endtask

  task automatic testStickyIrq();
    logic [7:0] d;
    minuteTick(8'h45, 8'h12, 8'h01);
    repeat (5) @(negedge clk);
    busWrite(5'd14, 8'h55);
    busRead(5'd2, d);
    check("R8 sticky past other access", {7'd0, alarmFlag}, 8'h01);
    check("R10 irq off when disabled", {7'd0, alarmIrqN}, 8'h01);
    @(negedge clk); irqEnable = 1'b1; #1;
    check("R10 irq low when enabled", {7'd0, alarmIrqN}, 8'h00);
    @(negedge clk); irqEnable = 1'b0;
    @(negedge clk);
    check("R10 enable keeps flag", {7'd0, alarmFlag}, 8'h01);
    irqEnable = 1'b1;
    busWrite(5'd7, 8'h01);
    check("R9 write clears", {7'd0, alarmFlag}, 8'h00);
    check("R10 irq released", {7'd0, alarmIrqN}, 8'h01);
  endtask

  task automatic testCollision();
    @(negedge clk); curMin = 8'h45; curHour = 8'h12; curDay = 8'h01; hund99 = 1'b1;
    @(negedge clk); hund99 = 1'b0; secRoll = 1'b1; busAddr = 5'd3; busRdEn = 1'b1;
    @(negedge clk); secRoll = 1'b0; busRdEn = 1'b0;
    check("R9 commit beats access", {7'd0, alarmFlag}, 8'h01);
    clearFlag();
    check("R9 later access clears", {7'd0, alarmFlag}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegisters();
    testExact();
    testMasks();
    testSampling();
    testStickyIrq();
    testCollision();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule